// File: doc/BRIEF.md
# Dual-Direction Word FIFO with Threshold Requests

This block places two word queues, each 16 entries deep, between a serial port and a processor bus. The outbound queue is written by the bus and emptied by the serial side. The inbound queue is filled by the serial side and read by the bus. Each queue raises a level-type transfer request toward a DMA engine or the processor. A 3-bit threshold code picks the fill level at which that request rises. The threshold code never changes how many words a queue can hold.

The bus side reads a single 16-bit status word. It carries the space left in the outbound queue, the words waiting in the inbound queue, and both threshold codes. Either direction can be emptied on its own by a synchronous clear. The clear restores that direction's count to its reset value and drops its sticky error flags. Threshold codes are written through a small configuration strobe and return to 000 only on the global reset.

Top module: `sfifo_pair`

## Requirements
- R1: After `rst`, the outbound free space is 16, the inbound stored count is 0, both threshold codes are 000, `txReq` is 1, `rxReq` is 0 and all four error flags are 0.
- R2: Each accepted `busWr` lowers the outbound free space by one at the next clock edge. Words leave on `serTxData` in the order they were written, and `serTxData` shows the oldest word while the queue is not empty.
- R3: A write to a full queue (`busWr` with outbound free space 0, or `serRxPush` with 16 inbound words) is dropped and leaves the count unchanged. It sets that direction's overflow flag (`txOvf` or `rxOvf`), which stays set until a clear.
- R4: A read from an empty queue (`serTxPop` with 16 free outbound slots, or `busRd` with 0 inbound words) is dropped and leaves the count unchanged. It sets that direction's underflow flag (`txUnf` or `rxUnf`), which stays set until a clear.
- R5: A write and a read in the same cycle on a non-empty queue, including a full one, leave the count unchanged and raise no flag. On an empty queue the write is taken and the read is dropped with an underflow.
- R6: Every threshold code gives the same capacity: 16 writes are accepted and the 17th overflows.
- R7: `txReq` follows the outbound free space F. Code 0xx (codes 0 to 3) requests when F = 16, code 100 when F > 12, code 101 when F > 8, code 110 when F > 4 and code 111 when F > 1.
- R8: `rxReq` follows the inbound stored count S. Code 0xx requests when S >= 1, code 100 when S > 4, code 101 when S > 8, code 110 when S > 12 and code 111 when S = 16.
- R9: Both requests are combinational on the current counts. They change in the same cycle as the count and drop as soon as their condition fails.
- R10: `txClr` sets the outbound free space to 16 and clears `txOvf` and `txUnf`, leaving the inbound side untouched. `rxClr` does the same for the inbound side: the count goes to 0 and `rxOvf` and `rxUnf` clear.
- R11: `regRdData` holds the outbound free space in bits 4:0, the inbound stored count in bits 9:5, the outbound code in bits 12:10 and the inbound code in bits 15:13. A `cfgWrEn` loads the outbound code from `cfgWrData[2:0]` and the inbound code from `cfgWrData[5:3]`.
- R12: Words pushed by `serRxPush` come out on `busRdData` in arrival order, and `busRdData` shows the oldest word while the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset for the whole block, active high |
| txClr | input | 1 | Synchronous clear of the outbound queue |
| rxClr | input | 1 | Synchronous clear of the inbound queue |
| cfgWrEn | input | 1 | Load strobe for both threshold codes |
| cfgWrData | input | 6 | [2:0] outbound code, [5:3] inbound code |
| busWr | input | 1 | Bus writes a word into the outbound queue |
| busWrData | input | W | Word written by the bus |
| serTxPop | input | 1 | Serial side takes the oldest outbound word |
| serTxData | output | W | Oldest outbound word |
| serRxPush | input | 1 | Serial side stores a word in the inbound queue |
| serRxData | input | W | Word stored by the serial side |
| busRd | input | 1 | Bus takes the oldest inbound word |
| busRdData | output | W | Oldest inbound word |
| regRdData | output | 16 | Status word: counts and threshold codes |
| txReq | output | 1 | Outbound transfer request |
| rxReq | output | 1 | Inbound transfer request |
| txOvf | output | 1 | Sticky outbound overflow |
| txUnf | output | 1 | Sticky outbound underflow |
| rxOvf | output | 1 | Sticky inbound overflow |
| rxUnf | output | 1 | Sticky inbound underflow |

## Verification
Counts, error flags and threshold codes are registered, so they change on the first clock edge after the strobe. The requests and the head-of-queue words are combinational on those registers and change in the same cycle. The bench drives every strobe on a falling edge, lets exactly one rising edge pass, and samples everything at the next falling edge. The scoreboard checks the outbound and inbound head word one nanosecond after the strobe is driven, before the rising edge that removes it from the queue.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // width of a threshold code
  localparam int MARK_W = 3;

  // per-direction strobes from control to storage
  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } dirStrobe_t;

  typedef struct packed {
    dirStrobe_t tx;
    dirStrobe_t rx;
  } fifoStrobes_t;
endpackage

// File: rtl/sfifo_data.sv
module sfifo_data
  import sfifo_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  fifoStrobes_t stb,
  input  logic [W-1:0] txWrData,
  input  logic [W-1:0] rxWrData,
  output logic [W-1:0] txHead,
  output logic [W-1:0] rxHead
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  dirStrobe_t   dirStb [2];
  logic [W-1:0] dirIn  [2];
  logic [W-1:0] dirOut [2];

  always_comb begin
    dirStb[0] = stb.tx;
    dirStb[1] = stb.rx;
    dirIn[0]  = txWrData;
    dirIn[1]  = rxWrData;
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
      if (dirStb[d].clr) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (dirStb[d].push) wrPtr <= bump(wrPtr);
        if (dirStb[d].pop)  rdPtr <= bump(rdPtr);
      end
    end

    always_ff @(posedge clk) begin
      if (dirStb[d].push) mem[wrPtr] <= dirIn[d];
    end

    assign dirOut[d] = mem[rdPtr];
  end

  assign txHead = dirOut[0];
  assign rxHead = dirOut[1];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                txClr,
  input  logic                rxClr,
  input  logic                cfgWrEn,
  input  logic [2*MARK_W-1:0] cfgWrData,
  input  logic                busWr,
  input  logic                serTxPop,
  input  logic                serRxPush,
  input  logic                busRd,
  output fifoStrobes_t        stb,
  output logic [CNT_W-1:0]    txRoom,
  output logic [CNT_W-1:0]    rxCount,
  output logic [MARK_W-1:0]   txMark,
  output logic [MARK_W-1:0]   rxMark,
  output logic                txReq,
  output logic                rxReq,
  output logic [1:0]          ovf,
  output logic [1:0]          unf
);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] QTR   = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] HALF  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TQTR  = CNT_W'((3 * DEPTH) / 4);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [1:0]       pushIn, popIn, clrIn, pushOk, popOk;
  logic [CNT_W-1:0] cnt [2];

  always_comb begin
    pushIn = {serRxPush, busWr};
    popIn  = {busRd, serTxPop};
    clrIn  = {rst || rxClr, rst || txClr};
  end

  for (genvar d = 0; d < 2; d++) begin : g_cnt
    always_comb begin
      popOk[d]  = popIn[d] && (cnt[d] != '0);
      pushOk[d] = pushIn[d] && ((cnt[d] != FULL) || popOk[d]);
    end

    always_ff @(posedge clk) begin
      if (clrIn[d]) begin
        cnt[d] <= '0;
        ovf[d] <= 1'b0;
        unf[d] <= 1'b0;
      end else begin
        cnt[d] <= cnt[d] + CNT_W'(pushOk[d]) - CNT_W'(popOk[d]);
        if (pushIn[d] && !pushOk[d]) ovf[d] <= 1'b1;
        if (popIn[d] && !popOk[d])   unf[d] <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.tx.clr  = clrIn[0];
    stb.tx.push = pushOk[0] && !clrIn[0];
    stb.tx.pop  = popOk[0] && !clrIn[0];
    stb.rx.clr  = clrIn[1];
    stb.rx.push = pushOk[1] && !clrIn[1];
    stb.rx.pop  = popOk[1] && !clrIn[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txMark <= '0;
      rxMark <= '0;
    end else if (cfgWrEn) begin
      txMark <= cfgWrData[MARK_W-1:0];
      rxMark <= cfgWrData[2*MARK_W-1:MARK_W];
    end
  end

  assign txRoom  = FULL - cnt[0];
  assign rxCount = cnt[1];

  // outbound: request on free space
  always_comb begin
    if (!txMark[2]) txReq = (txRoom == FULL);
    else begin
      case (txMark[1:0])
        2'b00:   txReq = txRoom > TQTR;
        2'b01:   txReq = txRoom > HALF;
        2'b10:   txReq = txRoom > QTR;
        default: txReq = txRoom > ONE;
      endcase
    end
  end

  // inbound: request on stored words
  always_comb begin
    if (!rxMark[2]) rxReq = (rxCount >= ONE);
    else begin
      case (rxMark[1:0])
        2'b00:   rxReq = rxCount > QTR;
        2'b01:   rxReq = rxCount > HALF;
        2'b10:   rxReq = rxCount > TQTR;
        default: rxReq = rxCount == FULL;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair
  import sfifo_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int RB_W  = 2 * CNT_W + 2 * MARK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                txClr,
  input  logic                rxClr,
  input  logic                cfgWrEn,
  input  logic [2*MARK_W-1:0] cfgWrData,
  input  logic                busWr,
  input  logic [W-1:0]        busWrData,
  input  logic                serTxPop,
  output logic [W-1:0]        serTxData,
  input  logic                serRxPush,
  input  logic [W-1:0]        serRxData,
  input  logic                busRd,
  output logic [W-1:0]        busRdData,
  output logic [RB_W-1:0]     regRdData,
  output logic                txReq,
  output logic                rxReq,
  output logic                txOvf,
  output logic                txUnf,
  output logic                rxOvf,
  output logic                rxUnf
);
  fifoStrobes_t      stb;
  logic [CNT_W-1:0]  txRoom, rxCount;
  logic [MARK_W-1:0] txMark, rxMark;
  logic [1:0]        ovf, unf;

  sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .txClr(txClr), .rxClr(rxClr),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .busWr(busWr), .serTxPop(serTxPop), .serRxPush(serRxPush), .busRd(busRd),
    .stb(stb), .txRoom(txRoom), .rxCount(rxCount),
    .txMark(txMark), .rxMark(rxMark), .txReq(txReq), .rxReq(rxReq),
    .ovf(ovf), .unf(unf)
  );

  sfifo_data #(.W(W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .stb(stb),
    .txWrData(busWrData), .rxWrData(serRxData),
    .txHead(serTxData), .rxHead(busRdData)
  );

  assign regRdData = {rxMark, txMark, rxCount, txRoom};
  assign txOvf = ovf[0];
  assign txUnf = unf[0];
  assign rxOvf = ovf[1];
  assign rxUnf = unf[1];
endmodule

// File: rtl/sfifo_pair_chk.sv
module sfifo_pair_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             txClr,
  input logic             rxClr,
  input logic             busWr,
  input logic             serTxPop,
  input logic             serRxPush,
  input logic             busRd,
  input logic [CNT_W-1:0] txRoom,
  input logic [CNT_W-1:0] rxCount,
  input logic [2:0]       txMark,
  input logic [2:0]       rxMark,
  input logic             txReq,
  input logic             rxReq,
  input logic             txOvf,
  input logic             txUnf,
  input logic             rxOvf,
  input logic             rxUnf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  assert_room_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (txRoom <= FULL) && (rxCount <= FULL));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (txRoom == '0) && busWr && !serTxPop && !txClr |=> (txRoom == '0) && txOvf);

  assert_rx_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (rxCount == FULL) && serRxPush && !busRd && !rxClr |=> (rxCount == FULL) && rxOvf);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    txOvf && !txClr |=> txOvf);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (rxCount == '0) && busRd && !serRxPush && !rxClr |=> (rxCount == '0) && rxUnf);

  assert_unf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    rxUnf && !rxClr |=> rxUnf);

  assert_push_pop_R5: assert property (@(posedge clk) disable iff (rst)
    busWr && serTxPop && (txRoom != FULL) && !txClr |=> $stable(txRoom));

  assert_tx_clear_R10: assert property (@(posedge clk) disable iff (rst)
    txClr |=> (txRoom == FULL) && !txOvf && !txUnf);

  assert_rx_clear_R10: assert property (@(posedge clk) disable iff (rst)
    rxClr |=> (rxCount == '0) && !rxOvf && !rxUnf);

  assert_tx_full_noreq_R7: assert property (@(posedge clk) disable iff (rst)
    (txRoom == '0) |-> !txReq);

  assert_tx_empty_req_R7: assert property (@(posedge clk) disable iff (rst)
    (txRoom == FULL) |-> txReq);

  assert_rx_empty_noreq_R8: assert property (@(posedge clk) disable iff (rst)
    (rxCount == '0) |-> !rxReq);

  assert_rx_full_req_R8: assert property (@(posedge clk) disable iff (rst)
    (rxCount == FULL) |-> rxReq);
endmodule

bind sfifo_pair sfifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .txClr(txClr), .rxClr(rxClr),
  .busWr(busWr), .serTxPop(serTxPop), .serRxPush(serRxPush), .busRd(busRd),
  .txRoom(regRdData[CNT_W-1:0]), .rxCount(regRdData[2*CNT_W-1:CNT_W]),
  .txMark(regRdData[2*CNT_W+2:2*CNT_W]), .rxMark(regRdData[2*CNT_W+5:2*CNT_W+3]),
  .txReq(txReq), .rxReq(rxReq),
  .txOvf(txOvf), .txUnf(txUnf), .rxOvf(rxOvf), .rxUnf(rxUnf)
);

// File: tb/sfifo_pair_test.sv
`timescale 1ns/1ps
module sfifo_pair_test;
  localparam int W = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst, txClr, rxClr, cfgWrEn, busWr, serTxPop, serRxPush, busRd;
  logic [5:0]   cfgWrData;
  logic [W-1:0] busWrData, serTxData, serRxData, busRdData;
  logic [15:0]  regRdData;
  logic txReq, rxReq, txOvf, txUnf, rxOvf, rxUnf;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit txPopExp = 0;
  bit rxPopExp = 0;
  logic [W-1:0] txQ[$];
  logic [W-1:0] rxQ[$];

  always #2 clk = ~clk;

  sfifo_pair #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .txClr(txClr), .rxClr(rxClr),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .busWr(busWr), .busWrData(busWrData),
    .serTxPop(serTxPop), .serTxData(serTxData),
    .serRxPush(serRxPush), .serRxData(serRxData),
    .busRd(busRd), .busRdData(busRdData),
    .regRdData(regRdData), .txReq(txReq), .rxReq(rxReq),
    .txOvf(txOvf), .txUnf(txUnf), .rxOvf(rxOvf), .rxUnf(rxUnf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic txExp(input int mark, input int room);
    if (mark < 4) return room == 16;
    case (mark)
      4: return room > 12;
      5: return room > 8;
      6: return room > 4;
      default: return room > 1;
    endcase
  endfunction

  function automatic logic rxExp(input int mark, input int cnt);
    if (mark < 4) return cnt >= 1;
    case (mark)
      4: return cnt > 4;
      5: return cnt > 8;
      6: return cnt > 12;
      default: return cnt == 16;
    endcase
  endfunction

  // called on a falling edge, returns on the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic txWrite(input logic [W-1:0] d);
    busWr = 1; busWrData = d;
    if (txQ.size() < DEPTH) txQ.push_back(d);
    step();
    busWr = 0;
  endtask

  task automatic txRead();
    serTxPop = 1; txPopExp = (txQ.size() > 0);
    step();
    serTxPop = 0; txPopExp = 0;
  endtask

  task automatic txBoth(input logic [W-1:0] d);
    busWr = 1; busWrData = d; serTxPop = 1;
    txPopExp = (txQ.size() > 0);
    if (txQ.size() < DEPTH || txPopExp) txQ.push_back(d);
    step();
    busWr = 0; serTxPop = 0; txPopExp = 0;
  endtask

  task automatic rxWrite(input logic [W-1:0] d);
    serRxPush = 1; serRxData = d;
    if (rxQ.size() < DEPTH) rxQ.push_back(d);
    step();
    serRxPush = 0;
  endtask

  task automatic rxRead();
    busRd = 1; rxPopExp = (rxQ.size() > 0);
    step();
    busRd = 0; rxPopExp = 0;
  endtask

  task automatic rxBoth(input logic [W-1:0] d);
    serRxPush = 1; serRxData = d; busRd = 1;
    rxPopExp = (rxQ.size() > 0);
    if (rxQ.size() < DEPTH || rxPopExp) rxQ.push_back(d);
    step();
    serRxPush = 0; busRd = 0; rxPopExp = 0;
  endtask

  task automatic clearTx();
    txClr = 1; step(); txClr = 0; txQ.delete();
  endtask

  task automatic clearRx();
    rxClr = 1; step(); rxClr = 0; rxQ.delete();
  endtask

  task automatic setMarks(input int t, input int r);
    cfgWrEn = 1; cfgWrData = {3'(r), 3'(t)};
    step();
    cfgWrEn = 0;
  endtask

  // scoreboard monitor: compares the head word just before the edge that removes it
  always @(negedge clk) begin
    #1;
    if (txPopExp && txQ.size() > 0) begin
      check("R2 outbound order", 32'(serTxData), 32'(txQ[0]));
      void'(txQ.pop_front());
    end
    if (rxPopExp && rxQ.size() > 0) begin
      check("R12 inbound order", 32'(busRdData), 32'(rxQ[0]));
      void'(rxQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int marks[6] = '{0, 3, 4, 5, 6, 7};
    rst = 1; txClr = 0; rxClr = 0; cfgWrEn = 0; cfgWrData = '0;
    busWr = 0; busWrData = '0; serTxPop = 0; serRxPush = 0; serRxData = '0; busRd = 0;
    repeat (3) @(negedge clk);

    // R1 / R11 reset state
    check("R1 R11 status word", 32'(regRdData), 32'h0010);
    check("R1 txReq", 32'(txReq), 1);
    check("R1 rxReq", 32'(rxReq), 0);
    check("R1 flags", 32'({txOvf, txUnf, rxOvf, rxUnf}), 0);
    rst = 0;
    step();

    // R7 / R6 / R3: outbound thresholds and capacity for every code
    foreach (marks[i]) begin
      setMarks(marks[i], 0);
      clearTx();
      for (int n = 0; n <= DEPTH; n++) begin
        check($sformatf("R7 txReq code=%0d fill=%0d", marks[i], n), 32'(txReq), 32'(txExp(marks[i], DEPTH - n)));
        check("R2 free space", 32'(regRdData[4:0]), 32'(DEPTH - n));
        txWrite(16'h1000 + 16'(n));
      end
      check("R6 R3 outbound stays full", 32'(regRdData[4:0]), 0);
      check("R3 txOvf set", 32'(txOvf), 1);
      clearTx();
    end

    // R8 / R6 / R3: inbound thresholds and capacity for every code
    foreach (marks[i]) begin
      setMarks(0, marks[i]);
      clearRx();
      for (int n = 0; n <= DEPTH; n++) begin
        check($sformatf("R8 rxReq code=%0d fill=%0d", marks[i], n), 32'(rxReq), 32'(rxExp(marks[i], n)));
        check("R8 stored count", 32'(regRdData[9:5]), 32'(n));
        rxWrite(16'h2000 + 16'(n));
      end
      check("R6 R3 inbound stays full", 32'(regRdData[9:5]), 16);
      check("R3 rxOvf set", 32'(rxOvf), 1);
      if (i != 5) clearRx();
    end

    // R10 independent clears (inbound still full with overflow)
    txWrite(16'h0A01); txWrite(16'h0A02); txWrite(16'h0A03);
    check("R10 outbound before clear", 32'(regRdData[4:0]), 13);
    clearTx();
    check("R10 outbound restored", 32'(regRdData[4:0]), 16);
    check("R10 tx flags cleared", 32'({txOvf, txUnf}), 0);
    check("R10 inbound untouched count", 32'(regRdData[9:5]), 16);
    check("R10 inbound untouched flag", 32'(rxOvf), 1);
    clearRx();
    check("R10 inbound restored", 32'(regRdData[9:5]), 0);
    check("R10 rx flags cleared", 32'({rxOvf, rxUnf}), 0);

    // R4 underflow
    txRead();
    check("R4 txUnf set", 32'(txUnf), 1);
    check("R4 outbound unchanged", 32'(regRdData[4:0]), 16);
    check("R4 no txOvf", 32'(txOvf), 0);
    rxRead();
    check("R4 rxUnf set", 32'(rxUnf), 1);
    check("R4 inbound unchanged", 32'(regRdData[9:5]), 0);
    step();
    check("R4 rxUnf sticky", 32'(rxUnf), 1);
    clearTx(); clearRx();

    // R2 / R12 ordering through the scoreboard
    for (int i = 0; i < 10; i++) txWrite(16'hA000 + 16'(i * 7));
    check("R2 ten written", 32'(regRdData[4:0]), 6);
    for (int i = 0; i < 10; i++) txRead();
    check("R2 drained", 32'(regRdData[4:0]), 16);
    for (int i = 0; i < 9; i++) rxWrite(16'h5000 + 16'(i * 3));
    for (int i = 0; i < 9; i++) rxRead();
    check("R12 drained", 32'(regRdData[9:5]), 0);

    // R5 simultaneous write and read
    for (int i = 0; i < DEPTH; i++) txWrite(16'h3000 + 16'(i));
    for (int i = 0; i < 4; i++) begin
      txBoth(16'h3100 + 16'(i));
      check("R5 full both keeps count", 32'(regRdData[4:0]), 0);
      check("R5 full both no overflow", 32'(txOvf), 0);
    end
    for (int i = 0; i < DEPTH; i++) txRead();
    for (int i = 0; i < 5; i++) rxWrite(16'h6000 + 16'(i));
    for (int i = 0; i < 3; i++) begin
      rxBoth(16'h6100 + 16'(i));
      check("R5 mid both keeps count", 32'(regRdData[9:5]), 5);
    end
    for (int i = 0; i < 5; i++) rxRead();
    check("R5 inbound flags clean", 32'({rxOvf, rxUnf}), 0);
    txBoth(16'h7777);
    check("R5 empty both takes write", 32'(regRdData[4:0]), 15);
    check("R5 empty both underflows", 32'(txUnf), 1);
    txRead();
    clearTx();

    // R9 request drops in the cycle the count crosses
    setMarks(7, 7);
    for (int i = 0; i < 14; i++) txWrite(16'h4000 + 16'(i));
    check("R9 txReq at free 2", 32'(txReq), 1);
    txWrite(16'h40FF);
    check("R9 txReq at free 1", 32'(txReq), 0);
    txRead();
    check("R9 txReq back at free 2", 32'(txReq), 1);

    // R11 status word layout
    clearTx();
    setMarks(5, 6);
    txWrite(16'h0B01); txWrite(16'h0B02);
    rxWrite(16'h0C01); rxWrite(16'h0C02); rxWrite(16'h0C03);
    check("R11 status word", 32'(regRdData), 32'((6 << 13) | (5 << 10) | (3 << 5) | 14));
    txRead(); txRead();
    rxRead(); rxRead(); rxRead();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule